// File: doc/BRIEF.md
# Timestamp Compare Channels with Pulse Outputs

This block watches the running value of a timestamp counter with a set of independent compare channels. Each channel holds an armed compare value and one queued value behind it. When the counter equals the armed value, the channel sets its match flag. It may raise the shared interrupt, and it drives its output pin according to its mode: toggle, fixed-width high pulse, or silent.

After a match, the queued value becomes the armed one. Software can therefore keep one value ahead of the hardware and produce an unbroken train of pulses, such as one per second. The first value is written while the channel's mode is zero; it arms the channel directly. The mode is then set, and later writes go into the queue. The channel ignores a counter value that coincides with the counter's wrap indication, unless wrap matching is enabled.

Registers sit on a simple single-cycle port. Reads are combinational on `addr`. A write takes effect at the clock edge on which `wr_en` is high.

Top module: `cmp_pulse_unit`

## Requirements
- R1: After reset every channel has mode 0, its flag is clear, its armed value is 0, every pin is low and `irq` is low.
- R2: The status/control word of channel n is at 0x608+8n, with bit 0 the DMA request enable, bits 5:2 the mode, bit 6 the interrupt enable, bit 7 the match flag, and bit 1 and bits 31:8 reading zero. The global status word at 0x604 holds the flag of channel n in bit n.
- R3: A write to the compare word (0x60C+8n) arms the channel directly when its mode is 0 or it holds no armed value. Otherwise the write goes into the queue and overwrites any value already queued. A read of the compare word returns the armed value.
- R4: With a nonzero mode and an armed value equal to `count`, the flag reads 1 from the next clock edge on. With mode 0 the channel never matches.
- R5: Writing a control word with bit 7 set clears the flag; writing bit 7 as 0 leaves the flag unchanged. If a match occurs on the same edge as the clearing write, the match wins and the flag stays set.
- R6: On a match the queued value becomes the armed value. If nothing is queued, the channel disarms and does not match again until a new compare write.
- R7: In mode 0x5 the channel's pin inverts on each match, starting from the next clock edge.
- R8: In mode 0xF a match drives the pin high for exactly PULSE_LEN cycles, starting at the next clock edge.
- R9: `irq` is high exactly when some channel has both its flag and its interrupt enable set.
- R10: While `cnt_wrap` is high, no channel matches unless `wrap_match_en` is high.
- R11: A channel in mode 0 holds its pin low, including right after leaving a mode in which the pin was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| count | input | CW | Running timestamp counter value |
| cnt_wrap | input | 1 | High in the cycle the counter restarts from zero |
| wrap_match_en | input | 1 | Allows matches while `cnt_wrap` is high |
| pin_out | output | NCH | Per-channel output pins |
| irq | output | 1 | Combined interrupt request |

## Verification
Register reads are combinational, so a read result is due in the same cycle its address is driven. Flags, toggles, pulse starts and `irq` are due one clock edge after the counter presents the matching value, and a pulse lasts PULSE_LEN cycles from there. The driver drives inputs just after a rising edge and queues each expected value for the cycle in which it is due. The monitor compares the queue against the outputs at the falling edge. This keeps every comparison one half-period away from the edge that changed the value, and it lets the pulse train be checked cycle by cycle.

// File: rtl/cmp_pulse_unit.sv
module cmp_pulse_unit #(
  parameter int NCH       = 4,
  parameter int CW        = 32,
  parameter int AW        = 12,
  parameter int PULSE_LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wr_data,
  output logic [31:0]    rd_data,
  input  logic [CW-1:0]  count,
  input  logic           cnt_wrap,
  input  logic           wrap_match_en,
  output logic [NCH-1:0] pin_out,
  output logic           irq
);
  localparam int PW        = $clog2(PULSE_LEN + 1);
  localparam int GSR_OFS   = 'h604;
  localparam int CH_BASE   = 'h608;
  localparam int CH_STRIDE = 8;
  localparam logic [3:0] MODE_OFF = 4'h0;
  localparam logic [3:0] MODE_TGL = 4'h5;
  localparam logic [3:0] MODE_PLS = 4'hF;

  logic [NCH-1:0][3:0]    mode;
  logic [NCH-1:0][CW-1:0] act;
  logic [NCH-1:0] flag, ie, dre, act_vld, nxt_vld, hit, ctl_we, cmp_we;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [AW-1:0] CTL_A = AW'(CH_BASE + n * CH_STRIDE);
    localparam logic [AW-1:0] CMP_A = AW'(CH_BASE + n * CH_STRIDE + 4);

    logic [3:0]    md;
    logic          fl, en, dr, av, nv, tg;
    logic [CW-1:0] ac, nx;
    logic [PW-1:0] pc;

    assign ctl_we[n]  = wr_en && addr == CTL_A;
    assign cmp_we[n]  = wr_en && addr == CMP_A;
    assign hit[n]     = av && md != MODE_OFF && count == ac && (!cnt_wrap || wrap_match_en);
    assign mode[n]    = md;
    assign act[n]     = ac;
    assign flag[n]    = fl;
    assign ie[n]      = en;
    assign dre[n]     = dr;
    assign act_vld[n] = av;
    assign nxt_vld[n] = nv;
    assign pin_out[n] = (md == MODE_TGL) ? tg : (md == MODE_PLS) ? (pc != '0) : 1'b0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        md <= MODE_OFF; fl <= 1'b0; en <= 1'b0; dr <= 1'b0;
        av <= 1'b0; nv <= 1'b0; tg <= 1'b0;
        ac <= '0; nx <= '0; pc <= '0;
      end else begin
        if (ctl_we[n]) begin
          md <= wr_data[5:2];
          en <= wr_data[6];
          dr <= wr_data[0];
        end
        if (hit[n])                       fl <= 1'b1;
        else if (ctl_we[n] && wr_data[7]) fl <= 1'b0;

        if (hit[n]) begin
          ac <= nx;
          av <= nv;
          nv <= 1'b0;
        end
        if (md == MODE_OFF) nv <= 1'b0;
        if (cmp_we[n]) begin
          if (md == MODE_OFF || !av || (hit[n] && !nv)) begin
            ac <= wr_data[CW-1:0];
            av <= 1'b1;
          end else begin
            nx <= wr_data[CW-1:0];
            nv <= 1'b1;
          end
        end

        if (md == MODE_OFF)                tg <= 1'b0;
        else if (hit[n] && md == MODE_TGL) tg <= ~tg;

        if (md != MODE_PLS) pc <= '0;
        else if (hit[n])    pc <= PW'(PULSE_LEN);
        else if (pc != '0)  pc <= pc - 1'b1;
      end
  end

  assign irq = |(flag & ie);

  always_comb begin
    rd_data = '0;
    if (addr == AW'(GSR_OFS)) rd_data[NCH-1:0] = flag;
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(CH_BASE + n * CH_STRIDE))
        rd_data = {24'b0, flag[n], ie[n], mode[n], 1'b0, dre[n]};
      if (addr == AW'(CH_BASE + n * CH_STRIDE + 4))
        rd_data = 32'(act[n]);
    end
  end
endmodule

// File: rtl/cmp_pulse_unit_chk.sv
module cmp_pulse_unit_chk #(
  parameter int NCH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               cnt_wrap,
  input logic               wrap_match_en,
  input logic               irq,
  input logic [NCH-1:0]     pin_out,
  input logic [NCH-1:0]     hit,
  input logic [NCH-1:0]     flag,
  input logic [NCH-1:0]     act_vld,
  input logic [NCH-1:0]     nxt_vld,
  input logic [NCH-1:0]     cmp_we,
  input logic [NCH-1:0][3:0] mode
);
  for (genvar n = 0; n < NCH; n++) begin : g_a
    assert_flag_from_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag[n]) |-> $past(hit[n]));
    assert_pulse_from_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pin_out[n]) && mode[n] == 4'hF) |-> $past(hit[n]));
    assert_disarm_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[n] && !nxt_vld[n] && !cmp_we[n]) |=> !act_vld[n]);
  end

  assert_wrap_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wrap && !wrap_match_en) |-> (hit == '0));
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|hit) || wr_en));
endmodule

bind cmp_pulse_unit cmp_pulse_unit_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cnt_wrap(cnt_wrap),
  .wrap_match_en(wrap_match_en), .irq(irq), .pin_out(pin_out), .hit(hit),
  .flag(flag), .act_vld(act_vld), .nxt_vld(nxt_vld), .cmp_we(cmp_we), .mode(mode)
);

// File: tb/cmp_pulse_unit_bench.sv
module cmp_pulse_unit_bench;
  localparam int NCH = 4, CW = 32, AW = 12, PLEN = 4;
  localparam logic [31:0] IDLE = 32'h7000_0000;

  logic clk = 0, rst_n = 0, wr_en = 0, cnt_wrap = 0, wrap_match_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [CW-1:0] count = IDLE;
  logic [NCH-1:0] pin_out;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_pulse_unit #(.NCH(NCH), .CW(CW), .AW(AW), .PULSE_LEN(PLEN)) u_cmp_pulse_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .count(count), .cnt_wrap(cnt_wrap),
    .wrap_match_en(wrap_match_en), .pin_out(pin_out), .irq(irq));

  typedef struct { int sel; logic [31:0] exp; string req; } item_t;
  item_t sbq[$];

  always @(negedge clk)
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sbq.pop_front();
      case (it.sel)
        0: got = rd_data;
        1: got = 32'(pin_out);
        default: got = 32'(irq);
      endcase
      checks++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
      end
    end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    tick(); wr_en = 1; addr = a; wr_data = d;
    tick(); wr_en = 0;
  endtask

  task automatic push(input int sel, input logic [31:0] e, input string req);
    item_t it;
    it.sel = sel; it.exp = e; it.req = req;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic exp_rd(input logic [AW-1:0] a, input logic [31:0] e, input string req);
    addr = a; push(0, e, req);
  endtask
  task automatic exp_pin(input logic [NCH-1:0] e, input string req); push(1, 32'(e), req); endtask
  task automatic exp_irq(input logic e, input string req); push(2, 32'(e), req); endtask

  task automatic hit_at(input logic [CW-1:0] v, input logic w);
    count = v; cnt_wrap = w;
    tick();
    count = IDLE; cnt_wrap = 0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    exp_rd(12'h608, 32'h0, "R1 ctrl0 reset");
    exp_rd(12'h604, 32'h0, "R1 global status reset");
    exp_rd(12'h60C, 32'h0, "R1 armed value reset");
    exp_pin(4'b0000, "R1 pins reset");
    exp_irq(1'b0, "R1 irq reset");

    // channel 0: pulse mode with queue
    wr(12'h608, 32'h0);
    wr(12'h60C, 32'd100);
    exp_rd(12'h60C, 32'd100, "R3 mode0 write arms");
    wr(12'h608, 32'h7D);
    wr(12'h60C, 32'd200);
    wr(12'h60C, 32'd300);
    exp_rd(12'h60C, 32'd100, "R3 queued writes keep armed value");
    exp_rd(12'h608, 32'h7D, "R2 ctrl field readback");
    hit_at(32'd100, 1'b0);
    for (int i = 0; i < PLEN; i++) begin
      exp_pin(4'b0001, "R8 pulse high");
      tick();
    end
    exp_pin(4'b0000, "R8 pulse ends after PULSE_LEN");
    exp_irq(1'b1, "R9 irq flag and enable");
    exp_rd(12'h608, 32'hFD, "R4 flag set by match");
    exp_rd(12'h604, 32'h1, "R2 global status bit0");
    exp_rd(12'h60C, 32'd300, "R6 queued value armed, R3 overwrite");
    wr(12'h608, 32'hFC);
    exp_rd(12'h608, 32'h7C, "R5 write one clears flag");
    exp_irq(1'b0, "R9 irq drops with flag");
    hit_at(32'd200, 1'b0);
    exp_rd(12'h608, 32'h7C, "R3 overwritten value never matches");
    hit_at(32'd300, 1'b0);
    exp_rd(12'h608, 32'hFC, "R4 second match");
    wr(12'h608, 32'h7C);
    exp_rd(12'h608, 32'hFC, "R5 write zero keeps flag");
    wr(12'h608, 32'hFC);
    hit_at(32'd300, 1'b0);
    exp_rd(12'h608, 32'h7C, "R6 disarmed after empty queue");

    // channel 1: toggle mode
    wr(12'h610, 32'h0);
    wr(12'h614, 32'd50);
    wr(12'h610, 32'h14);
    wr(12'h614, 32'd60);
    exp_pin(4'b0000, "R7 toggle starts low");
    hit_at(32'd50, 1'b0);
    exp_pin(4'b0010, "R7 toggle first match");
    exp_irq(1'b0, "R9 flag without enable");
    hit_at(32'd60, 1'b0);
    exp_pin(4'b0000, "R7 toggle second match");
    exp_rd(12'h604, 32'h2, "R2 global status bit1");
    wr(12'h614, 32'd80);
    exp_rd(12'h614, 32'd80, "R3 write arms disarmed channel");
    hit_at(32'd80, 1'b0);
    exp_pin(4'b0010, "R7 toggle third match");
    wr(12'h610, 32'h0);
    exp_pin(4'b0000, "R11 mode0 forces pin low");

    // channel 2: mode 0 never matches
    wr(12'h61C, 32'd70);
    hit_at(32'd70, 1'b0);
    exp_rd(12'h618, 32'h0, "R4 mode0 no match");

    // channel 3: wrap gating
    wr(12'h624, 32'd0);
    wr(12'h620, 32'h3C);
    wrap_match_en = 0;
    hit_at(32'd0, 1'b1);
    exp_rd(12'h620, 32'h3C, "R10 wrap match suppressed");
    wrap_match_en = 1;
    hit_at(32'd0, 1'b1);
    exp_pin(4'b1000, "R10 R8 wrap match pulses");
    exp_rd(12'h620, 32'hBC, "R10 wrap match allowed");

    repeat (2) tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule